// File: doc/BRIEF.md
# Cascaded Serial DAC Update Master

This block drives a chain of cascaded dual-channel 12-bit serial DACs from the host side. All devices share one serial clock and one active-low select/load line. The master feeds the first device's data input, and each device's serial output feeds the next device's input. On a start pulse the master captures a flat vector of N×2 codes and pulls select low. It then shifts out N×24 bits, most significant bit first, and raises select once. The single rising edge of select loads every device in the chain at the same moment.

Every interface timing minimum is a parameter counted in system clock cycles:
- clock low before select falls;
- select low to the first clock rise;
- data setup before each rise;
- clock high and clock low widths;
- last clock to select rise;
- select high (load) width.

Hold time is zero. Data changes only while the serial clock is low, so it is held for the whole high phase. The bits for the farthest device leave first, so after the full frame each device holds its own word. A `busy` flag covers the whole transaction. A one-cycle `done` pulse marks the end of the load window.

Top module: `dchain_dac_master`

## Requirements
- R1: Each device receives a 24-bit word: channel A's 12 bits, then channel B's 12 bits, each MSB first. Input packing: `codes[(2*d+c)*12 +: 12]`, where d=0 is the device wired directly to the master and c=0 is channel A.
- R2: The word for device N-1 (the farthest) is shifted first and device 0's word last. Exactly N×24 serial clock rises occur per frame.
- R3: On an accepted start, select stays high and the serial clock stays low for T_PRE cycles before select falls. The serial clock is never high while select is high.
- R4: The first data bit is presented in the same cycle that select falls. The first clock rise comes max(T_CSS, T_SU) cycles later.
- R5: Each clock high phase lasts exactly T_HIGH cycles. Each low phase between rises lasts max(T_LOW, T_SU) cycles. The data line changes only on a falling clock, so it is stable throughout every high phase.
- R6: After the last high phase, the clock is low and select stays low for T_CSH cycles. Select then rises and stays high for T_LDW cycles.
- R7: `busy` is high from the cycle after an accepted start until the load window ends. `done` pulses for exactly one cycle right after that window, in the same cycle that `busy` drops.
- R8: A start while `busy` is high is ignored and does not disturb the frame in progress. A start during the `done` cycle is accepted.
- R9: After reset, select is high and serial clock, data, `busy` and `done` are all low. The data line is 0 whenever select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| codes | input | N_DEV*2*CODE_W | DAC codes, packed as in R1 |
| ser_sclk | output | 1 | Shared serial clock to the chain |
| ser_sdata | output | 1 | Serial data into the first device |
| ser_sel_n | output | 1 | Shared active-low select; its rising edge loads all devices |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench reassembles each frame from the data line at every serial clock rise and compares it with the device-reversed packing. A design that sent the nearest device first, or swapped channels within a word, would leave every device holding the wrong codes. The bench sets T_SU above both T_LOW and T_CSS, so a design that timed only by the clock-width parameters would produce shortened low phases and an early first edge. A cycle-exact model catches these, as well as an off-by-one tail or load window, or a missing final clock. The bench also pulses start in the middle of a frame, which a design without the busy guard would restart. It then issues start during the `done` cycle, which a design that only re-armed a cycle later would drop.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_LOAD
    } dc_state_e;

    localparam int CH_PER_DEV = 2;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dchain_frame_pack.sv
module dchain_frame_pack #(
    parameter int N_DEV  = 3,
    parameter int CODE_W = 12,
    localparam int WORD_W = dchain_pkg::CH_PER_DEV * CODE_W,
    localparam int NBITS  = N_DEV * WORD_W
) (
    input  logic [NBITS-1:0] codes,
    output logic [NBITS-1:0] frame
);
    // frame[NBITS-1] leaves first: farthest device, channel A, MSB.
    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        localparam int DEV = N_DEV - 1 - (k / WORD_W);
        localparam int CH  = (k % WORD_W) / CODE_W;
        localparam int BIT = CODE_W - 1 - (k % CODE_W);
        assign frame[NBITS-1-k] = codes[(dchain_pkg::CH_PER_DEV*DEV + CH)*CODE_W + BIT];
    end
endmodule

// File: rtl/dchain_timer.sv
module dchain_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5: an idle counter rests at zero instead of wrapping
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/dchain_dac_master.sv
module dchain_dac_master
    import dchain_pkg::*;
#(
    parameter int N_DEV  = 3,
    parameter int CODE_W = 12,
    parameter int T_PRE  = 2,
    parameter int T_CSS  = 2,
    parameter int T_SU   = 2,
    parameter int T_HIGH = 3,
    parameter int T_LOW  = 3,
    parameter int T_CSH  = 2,
    parameter int T_LDW  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [N_DEV*CH_PER_DEV*CODE_W-1:0] codes,
    output logic                              ser_sclk,
    output logic                              ser_sdata,
    output logic                              ser_sel_n,
    output logic                              busy,
    output logic                              done
);
    localparam int NBITS   = N_DEV * CH_PER_DEV * CODE_W;
    localparam int S_CYC   = max2(T_CSS, T_SU);
    localparam int L_CYC   = max2(T_LOW, T_SU);
    localparam int MAX_DUR = max2(max2(max2(T_PRE, S_CYC), max2(T_HIGH, L_CYC)),
                                  max2(T_CSH, T_LDW));
    localparam int CNT_W   = $clog2(MAX_DUR + 1);
    localparam int BIT_W   = $clog2(NBITS);

    dc_state_e        state, st_nxt;
    logic [NBITS-1:0] frame, shreg;
    logic [BIT_W-1:0] bitcnt;
    logic             tz, last_bit, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    dchain_frame_pack #(.N_DEV(N_DEV), .CODE_W(CODE_W)) u_pack (
        .codes (codes),
        .frame (frame)
    );

    dchain_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tz)
    );

    function automatic logic [CNT_W-1:0] dur_of(input dc_state_e s);
        case (s)
            ST_PRE:   return CNT_W'(T_PRE - 1);
            ST_SETUP: return CNT_W'(S_CYC - 1);
            ST_HIGH:  return CNT_W'(T_HIGH - 1);
            ST_LOW:   return CNT_W'(L_CYC - 1);
            ST_TAIL:  return CNT_W'(T_CSH - 1);
            ST_LOAD:  return CNT_W'(T_LDW - 1);
            default:  return '0;
        endcase
    endfunction

    assign last_bit = (bitcnt == BIT_W'(NBITS - 1));

    always_comb begin
        st_nxt = state;
        case (state)
            ST_IDLE:  if (start) st_nxt = ST_PRE;
            ST_PRE:   if (tz) st_nxt = ST_SETUP;
            ST_SETUP: if (tz) st_nxt = ST_HIGH;
            ST_HIGH:  if (tz) st_nxt = last_bit ? ST_TAIL : ST_LOW;
            ST_LOW:   if (tz) st_nxt = ST_HIGH;
            ST_TAIL:  if (tz) st_nxt = ST_LOAD;
            ST_LOAD:  if (tz) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
        tmr_load = (st_nxt != state);
        tmr_val  = dur_of(st_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            ser_sclk  <= 1'b0;
            ser_sdata <= 1'b0;
            ser_sel_n <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            state <= st_nxt;
            done  <= 1'b0;
            if (st_nxt != state) begin
                case (st_nxt)
                    ST_PRE: begin
                        shreg <= frame;
                        busy  <= 1'b1;
                    end
                    ST_SETUP: begin
                        ser_sel_n <= 1'b0;
                        ser_sdata <= shreg[NBITS-1];
                        shreg     <= shreg << 1;
                        bitcnt    <= '0;
                    end
                    ST_HIGH: ser_sclk <= 1'b1;
                    ST_LOW: begin
                        ser_sclk  <= 1'b0;
                        ser_sdata <= shreg[NBITS-1];
                        shreg     <= shreg << 1;
                        bitcnt    <= bitcnt + 1'b1;
                    end
                    ST_TAIL: ser_sclk <= 1'b0;
                    ST_LOAD: begin
                        ser_sel_n <= 1'b1;
                        ser_sdata <= 1'b0;
                    end
                    ST_IDLE: begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: serial clock is never high while select is high
    a_r3_sclk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        ser_sel_n |-> !ser_sclk);

    // R3: select only falls after a cycle with the clock low
    a_r3_sel_fall_clk_low: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_sel_n) |-> $past(!ser_sclk));

    // R5: data stable throughout each high phase (zero hold)
    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (rst)
        (ser_sclk && $past(ser_sclk)) |-> $stable(ser_sdata));

    // R7: done is a single-cycle pulse and coincides with busy low
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: start while busy does not end the transaction
    a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !ser_sel_n) |=> busy);

    // R9: data line is 0 whenever select is high
    a_r9_data_idle_zero: assert property (@(posedge clk) disable iff (rst)
        ser_sel_n |-> !ser_sdata);
endmodule

// File: tb/dchain_dac_master_bench.sv
module dchain_dac_master_bench;
    localparam int N      = 2;
    localparam int CW     = 12;
    localparam int NB     = N * 24;
    localparam int T_PRE  = 1;
    localparam int T_CSS  = 3;
    localparam int T_SU   = 4;
    localparam int T_HIGH = 2;
    localparam int T_LOW  = 2;
    localparam int T_CSH  = 3;
    localparam int T_LDW  = 5;

    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic sdata;
        logic busy;
        logic done;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [NB-1:0] codes = '0;
    logic ser_sclk, ser_sdata, ser_sel_n, busy, done;

    always #5 clk = ~clk;

    dchain_dac_master #(
        .N_DEV(N), .CODE_W(CW), .T_PRE(T_PRE), .T_CSS(T_CSS), .T_SU(T_SU),
        .T_HIGH(T_HIGH), .T_LOW(T_LOW), .T_CSH(T_CSH), .T_LDW(T_LDW)
    ) u_dchain_dac_master (
        .clk(clk), .rst(rst), .start(start), .codes(codes),
        .ser_sclk(ser_sclk), .ser_sdata(ser_sdata), .ser_sel_n(ser_sel_n),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t q[$];
    logic [NB-1:0] cur_codes = '0;
    logic [NB-1:0] got_bits;
    int nrise = 0;
    logic prev_sclk = 0;
    logic prev_sel_n = 1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R1 R2: bit k of the stream, computed from the packing rule
    function automatic logic stream_bit(input logic [NB-1:0] c, input int k);
        int dev = N - 1 - k / 24;
        int ch  = (k % 24) / 12;
        int bi  = 11 - (k % 12);
        return c[(2 * dev + ch) * 12 + bi];
    endfunction

    function automatic exp_t mk(input logic s, input logic k, input logic d,
                                input logic b, input logic dn);
        exp_t e;
        e.sel_n = s; e.sclk = k; e.sdata = d; e.busy = b; e.done = dn;
        return e;
    endfunction

    task automatic push_frame(input logic [NB-1:0] c);
        for (int i = 0; i < T_PRE; i++) q.push_back(mk(1, 0, 0, 1, 0));
        for (int i = 0; i < imax(T_CSS, T_SU); i++) q.push_back(mk(0, 0, stream_bit(c, 0), 1, 0));
        for (int k = 0; k < NB; k++) begin
            for (int i = 0; i < T_HIGH; i++) q.push_back(mk(0, 1, stream_bit(c, k), 1, 0));
            if (k < NB - 1)
                for (int i = 0; i < imax(T_LOW, T_SU); i++) q.push_back(mk(0, 0, stream_bit(c, k + 1), 1, 0));
            else
                for (int i = 0; i < T_CSH; i++) q.push_back(mk(0, 0, stream_bit(c, k), 1, 0));
        end
        for (int i = 0; i < T_LDW; i++) q.push_back(mk(1, 0, 0, 1, 0));
        q.push_back(mk(1, 0, 0, 0, 1));
    endtask

    task automatic cmp(input string tag, input logic act, input logic exv);
        checks++;
        if (act !== exv) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cycles, act, exv);
        end
    endtask

    // Per-cycle model comparison and frame reassembly
    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            cycles++;
            e = (q.size() > 0) ? q.pop_front() : mk(1, 0, 0, 0, 0);
            cmp("R3 R6 sel_n", ser_sel_n, e.sel_n);
            cmp("R4 R5 sclk", ser_sclk, e.sclk);
            cmp("R1 R4 sdata", ser_sdata, e.sdata);
            cmp("R7 R8 busy", busy, e.busy);
            cmp("R7 done", done, e.done);
            if (ser_sclk && !prev_sclk) begin
                if (nrise < NB) got_bits[NB-1-nrise] = ser_sdata;
                nrise++;
            end
            if (ser_sel_n && !prev_sel_n) begin
                logic [NB-1:0] want;
                for (int k = 0; k < NB; k++) want[NB-1-k] = stream_bit(cur_codes, k);
                checks++;
                if (nrise != NB) begin
                    errors++;
                    $display("FAIL R2 rises actual %0d expected %0d", nrise, NB);
                end
                checks++;
                if (got_bits !== want) begin
                    errors++;
                    $display("FAIL R1 frame actual %h expected %h", got_bits, want);
                end
                // R1: device 0 channel B word ends the stream
                checks++;
                if (got_bits[11:0] !== cur_codes[23:12]) begin
                    errors++;
                    $display("FAIL R1 last word actual %h expected %h", got_bits[11:0], cur_codes[23:12]);
                end
                nrise = 0;
            end
            prev_sclk = ser_sclk;
            prev_sel_n = ser_sel_n;
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic issue(input logic [NB-1:0] c, input logic model_idle);
        @(negedge clk); #1;
        start = 1;
        codes = c;
        if (model_idle) begin
            push_frame(c);
            cur_codes = c;
        end
        @(negedge clk); #1;
        start = 0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        rst = 0;
        @(negedge clk); #2;
        // R9: reset state
        cmp("R9 reset sel_n", ser_sel_n, 1'b1);
        cmp("R9 reset sclk", ser_sclk, 1'b0);
        cmp("R9 reset sdata", ser_sdata, 1'b0);
        cmp("R9 reset busy", busy, 1'b0);
        cmp("R9 reset done", done, 1'b0);

        // R1 R2: distinct codes per device/channel
        issue({12'hA5C, 12'h3F1, 12'h801, 12'h7FE}, 1);
        wait_done();

        // R5: alternating pattern
        issue({12'h555, 12'hAAA, 12'hFFF, 12'h000}, 1);
        // R8: start pulsed mid-frame is ignored
        repeat (40) @(negedge clk);
        #1; start = 1; codes = {4{12'h123}};
        @(negedge clk); #1; start = 0;
        wait_done();
        // R8: start during the done cycle is accepted
        #1; start = 1; codes = {12'h001, 12'h800, 12'h0F0, 12'hF0F};
        push_frame(codes);
        cur_codes = codes;
        @(negedge clk); #1; start = 0;
        wait_done();

        repeat (10) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule